// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous static memory of 36-bit words: 32 data bits and 4 parity bits. Each operation's address and control are registered on a rising clock edge. Its data phase, read or write, falls exactly two enabled edges later. Because reads and writes share that fixed distance, the two can follow each other in any order on every cycle with no idle bus cycle between them. A global clock enable stalls the whole machine in place.

A small controller tracks the burst in progress. Its states are:

- `ST_IDLE`: no burst is open.
- `ST_RD_BURST`: a read burst is open.
- `ST_WR_BURST`: a write burst is open.

A selected load with `rw_n` high moves the controller to `ST_RD_BURST`, and a selected load with `rw_n` low moves it to `ST_WR_BURST`. Both moves happen from any state. A deselect moves it to `ST_IDLE` from any state. An advance cycle leaves the state unchanged. In a burst state, an advance issues one more operation of the same kind at the next address of a four-word sequence. A companion counter produces that sequence in linear or interleaved order.

The data bus is split into `dq_in`, `dq_out` and `dq_oe`. The output enable `oe_n` acts on `dq_oe` without waiting for a clock edge. The address width is a parameter, and the depth is `2**AW` words. Memory contents start undefined.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted at an enabled rising edge E drives the addressed word on `dq_out`, with `dq_oe` high, after enabled edge E+2. Only edges with `cen_n` low are counted.
- R2: A write command accepted at E stores the `dq_in` value sampled at enabled edge E+2. A read of that address accepted at E+1 or later returns the new word.
- R3: A command can be accepted at every enabled edge. Reads and writes may alternate freely with no idle cycle, and each keeps its own two-edge data phase.
- R4: While `cen_n` is high, every other input is ignored. The pipeline, burst state, memory and outputs all hold their values.
- R5: A deselect is a cycle with `adv_ld` low and any of `ce1_n` high, `ce2` low or `ce3_n` high. A deselect starts no operation and closes any open burst, but operations already in flight still complete. `dq_oe` is low after the second enabled edge following a deselect or a write command.
- R6: With `adv_ld` high in an open burst, the next address keeps the loaded upper bits. With `burst_linear`=1, the low two bits are (loaded low bits + n) mod 4 for the n-th advance, wrapping after four words.
- R7: With `burst_linear`=0, the low two address bits of the n-th advance are the loaded low bits XOR n.
- R8: An advance cycle while no burst is open (after reset or a deselect) starts no operation, whatever `rw_n` and the chip enables show.
- R9: `rw_n` and the chip enables are sampled only when `adv_ld` is low. An advance continues the operation type of its burst's load. `bw_n` is sampled on every command cycle, including advances.
- R10: A low `bw_n[k]` on a write's command cycle updates data bits [8k+7:8k] and parity bit 32+k. The bits of the other lanes keep their stored value.
- R11: `oe_n` high forces `dq_oe` low immediately, with no clock edge. Whenever `dq_oe` is low, `dq_out` is all zeros.
- R12: `rst_n` low empties the pipeline and closes any burst, so `dq_oe` is low. The memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline and burst state |
| cen_n | input | 1 | Active-low clock enable; high stalls everything |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| rw_n | input | 1 | 1 = read, 0 = write; sampled on loads |
| bw_n | input | 4 | Active-low byte-lane write selects |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address |
| dq_in | input | 36 | Write data, sampled at the data-phase edge |
| dq_out | output | 36 | Read data; zero when not driven |
| dq_oe | output | 1 | High while the block drives read data |

## Verification
Read data and `dq_oe` change right after the second enabled edge that follows the read's command edge. A write takes `dq_in` at its own second enabled edge, and `oe_n` acts with no edge at all. The bench keeps a reference pipeline that advances only on edges with `cen_n` low, so stall cycles add nothing to these distances. It compares the outputs at the falling edge after each rising edge, which is half a cycle after any registered change. `oe_n` is checked a few nanoseconds after it toggles, between edges.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int unsigned LANES     = 4;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned PAR_W     = LANES;
    localparam int unsigned WORD_W    = LANES * LANE_W + PAR_W;
    localparam int unsigned BURST_LEN = 4;
    localparam int unsigned BURST_BITS = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } burst_state_e;
endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          load,
    input  logic          advance,
    input  logic          linear,
    input  logic [AW-1:0] ld_addr,
    output logic [AW-1:0] cur_addr
);
    localparam int unsigned BB = BURST_BITS;

    logic [AW-1:0] base_q;
    logic [BB-1:0] cnt_q;
    logic [BB-1:0] cnt_nxt;
    logic [BB-1:0] low_adv;

    assign cnt_nxt = cnt_q + 1'b1;

    always_comb begin
        if (linear) begin
            low_adv = base_q[BB-1:0] + cnt_nxt;
        end else begin
            low_adv = base_q[BB-1:0] ^ cnt_nxt;
        end
        if (load) begin
            cur_addr = ld_addr;
        end else begin
            cur_addr = {base_q[AW-1:BB], low_adv};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!cen_n) begin
            if (load) begin
                base_q <= ld_addr;
                cnt_q  <= '0;
            end else if (advance) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R6: each accepted advance moves the burst index by one, modulo burst length
    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && advance && !load) |=> (cnt_q == BB'($past(cnt_q) + 1'b1)));

    // R4: stalled cycles leave the burst position untouched
    p_burst_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/zbt_cmd_fsm.sv
module zbt_cmd_fsm
    import zbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cen_n,
    input  logic adv_ld,
    input  logic sel,
    input  logic rw_n,
    output logic load,
    output logic advance,
    output logic issue_vld,
    output logic issue_wr
);
    burst_state_e state_q;
    burst_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RD_BURST, ST_WR_BURST: begin
                if (!adv_ld) begin
                    if (!sel) begin
                        state_d = ST_IDLE;
                    end else if (rw_n) begin
                        state_d = ST_RD_BURST;
                    end else begin
                        state_d = ST_WR_BURST;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!cen_n) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load      = !adv_ld && sel;
        advance   = 1'b0;
        issue_wr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                issue_wr = load && !rw_n;
            end
            ST_RD_BURST: begin
                advance  = adv_ld;
                issue_wr = load && !rw_n;
            end
            ST_WR_BURST: begin
                advance  = adv_ld;
                issue_wr = load ? !rw_n : 1'b1;
            end
            default: begin
                advance  = 1'b0;
                issue_wr = 1'b0;
            end
        endcase
        issue_vld = rst_n && !cen_n && (load || advance);
    end

    // R4: the burst state does not move during a stall
    p_state_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(state_q));

    // R5: a deselect closes any open burst
    p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !sel) |=> (state_q == ST_IDLE));

    // R8: advancing with no open burst keeps the controller idle
    p_adv_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/zbt_pipe_mem.sv
module zbt_pipe_mem
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              in_vld,
    input  logic              in_wr,
    input  logic [AW-1:0]     in_addr,
    input  logic [LANES-1:0]  in_bw_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_drive
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    logic              s1_vld, s2_vld;
    logic              s1_wr, s2_wr;
    logic [AW-1:0]     s1_addr, s2_addr;
    logic [LANES-1:0]  s1_bw_n, s2_bw_n;
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] rdata_q;
    logic              drive_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_mask[k*LANE_W +: LANE_W] = {LANE_W{~s2_bw_n[k]}};
        assign lane_mask[DATA_W + k]         = ~s2_bw_n[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s2_vld  <= 1'b0;
            s1_wr   <= 1'b0;
            s2_wr   <= 1'b0;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_bw_n <= '1;
            s2_bw_n <= '1;
            drive_q <= 1'b0;
            rdata_q <= '0;
        end else if (!cen_n) begin
            s1_vld  <= in_vld;
            s1_wr   <= in_wr;
            s1_addr <= in_addr;
            s1_bw_n <= in_bw_n;
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
            drive_q <= s2_vld && !s2_wr;
            if (s2_vld && !s2_wr) begin
                rdata_q <= mem[s2_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !cen_n && s2_vld && s2_wr) begin
            mem[s2_addr] <= (mem[s2_addr] & ~lane_mask) | (wdata & lane_mask);
        end
    end

    assign rdata    = rdata_q;
    assign rd_drive = drive_q;

    // R1: a read reaching its data phase turns the driver on
    p_rd_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && s2_vld && !s2_wr) |=> drive_q);

    // R5: a write reaching its data phase leaves the bus released
    p_wr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && s2_vld && s2_wr) |=> !drive_q);

    // R4: a stall freezes the data-phase stage and the output register
    p_pipe_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(s2_vld) && $stable(drive_q) && $stable(rdata_q)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              rw_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              adv_ld,
    input  logic              burst_linear,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              sel;
    logic              load;
    logic              advance;
    logic              issue_vld;
    logic              issue_wr;
    logic [AW-1:0]     op_addr;
    logic [WORD_W-1:0] rdata;
    logic              rd_drive;

    assign sel = !ce1_n && ce2 && !ce3_n;

    zbt_cmd_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cen_n     (cen_n),
        .adv_ld    (adv_ld),
        .sel       (sel),
        .rw_n      (rw_n),
        .load      (load),
        .advance   (advance),
        .issue_vld (issue_vld),
        .issue_wr  (issue_wr)
    );

    zbt_burst_ctr #(.AW(AW)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen_n    (cen_n),
        .load     (load),
        .advance  (advance),
        .linear   (burst_linear),
        .ld_addr  (addr),
        .cur_addr (op_addr)
    );

    zbt_pipe_mem #(.AW(AW)) i_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen_n    (cen_n),
        .in_vld   (issue_vld),
        .in_wr    (issue_wr),
        .in_addr  (op_addr),
        .in_bw_n  (bw_n),
        .wdata    (dq_in),
        .rdata    (rdata),
        .rd_drive (rd_drive)
    );

    assign dq_oe  = rd_drive && !oe_n;
    assign dq_out = dq_oe ? rdata : '0;

    // R1: a read issued two enabled edges ago is being driven now
    p_two_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && $past(!cen_n) && $past(!cen_n, 2) && $past(issue_vld && !issue_wr, 2))
            |=> rd_drive);

    // R5: a write issued two enabled edges ago never leaves the driver on
    p_wr_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && $past(!cen_n) && $past(!cen_n, 2) && $past(issue_vld && issue_wr, 2))
            |=> !rd_drive);
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
    import zbt_pkg::*;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int W     = WORD_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b0;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b0;
    logic          ce3_n = 1'b1;
    logic          rw_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          adv_ld = 1'b0;
    logic          burst_linear = 1'b1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  dq_in = '0;
    logic [W-1:0]  dq_out;
    logic          dq_oe;

    zbt_sram #(.AW(AW)) i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .rw_n(rw_n), .bw_n(bw_n), .adv_ld(adv_ld),
        .burst_linear(burst_linear), .oe_n(oe_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_tag = "R12";

    // reference model state
    logic [W-1:0]  shadow [DEPTH];
    logic [3:0]    sh_ok  [DEPTH];
    logic          p1_vld = 0, p2_vld = 0, p1_wr = 0, p2_wr = 0;
    logic [AW-1:0] p1_addr = '0, p2_addr = '0, m_base = '0;
    logic [3:0]    p1_bw = 4'hF, p2_bw = 4'hF;
    int            m_state = 0;
    int            m_cnt = 0;
    logic          exp_drv = 0;
    logic [W-1:0]  exp_data = '0;
    logic [3:0]    exp_ok = 4'h0;

    function automatic logic [W-1:0] lanes(input logic [3:0] en);
        logic [W-1:0] m = '0;
        for (int k = 0; k < 4; k++) begin
            m[k*8 +: 8] = {8{en[k]}};
            m[32 + k]   = en[k];
        end
        return m;
    endfunction

    function automatic logic [W-1:0] merge_word(input logic [W-1:0] old, input logic [W-1:0] nw,
                                                input logic [3:0] b_n);
        return (old & ~lanes(~b_n)) | (nw & lanes(~b_n));
    endfunction

    function automatic logic [W-1:0] rnd_word();
        return {4'($urandom), 32'($urandom)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs();
        logic eo;
        logic [W-1:0] mk;
        eo = exp_drv && !oe_n;
        chk(dq_oe == eo, {cur_tag, " dq_oe"}, W'(dq_oe), W'(eo));
        if (eo) begin
            mk = lanes(exp_ok);
            chk((dq_out & mk) == (exp_data & mk), {cur_tag, " dq_out"}, dq_out & mk, exp_data & mk);
        end else begin
            chk(dq_out == '0, "R11 released dq_out", dq_out, '0);
        end
    endtask

    task automatic tick();
        logic       sel;
        logic [1:0] low;
        @(posedge clk);
        if (!rst_n) begin
            p1_vld = 0; p2_vld = 0; exp_drv = 0; m_state = 0; m_cnt = 0;
        end else if (!cen_n) begin
            if (p2_vld && !p2_wr) begin
                exp_drv = 1; exp_data = shadow[p2_addr]; exp_ok = sh_ok[p2_addr];
            end else begin
                exp_drv = 0;
            end
            if (p2_vld && p2_wr) begin
                shadow[p2_addr] = merge_word(shadow[p2_addr], dq_in, p2_bw);
                sh_ok[p2_addr]  = sh_ok[p2_addr] | ~p2_bw;
            end
            p2_vld = p1_vld; p2_wr = p1_wr; p2_addr = p1_addr; p2_bw = p1_bw;
            sel   = !ce1_n && ce2 && !ce3_n;
            p1_bw = bw_n;
            if (!adv_ld) begin
                if (sel) begin
                    p1_vld = 1; p1_wr = !rw_n; p1_addr = addr;
                    m_base = addr; m_cnt = 0; m_state = rw_n ? 1 : 2;
                end else begin
                    p1_vld = 0; m_state = 0;
                end
            end else if (m_state != 0) begin
                m_cnt = (m_cnt + 1) % 4;
                low = burst_linear ? 2'(m_base[1:0] + 2'(m_cnt)) : (m_base[1:0] ^ 2'(m_cnt));
                p1_vld = 1; p1_wr = (m_state == 2); p1_addr = {m_base[AW-1:2], low};
            end else begin
                p1_vld = 0;
            end
        end
        @(negedge clk);
        chk_outputs();
    endtask

    task automatic set_nop();
        cen_n = 0; adv_ld = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; rw_n = 1'($urandom); bw_n = 4'hF;
    endtask

    task automatic set_load(input logic [AW-1:0] a, input logic rd, input logic [3:0] b);
        cen_n = 0; adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; rw_n = rd; addr = a; bw_n = b;
    endtask

    task automatic set_adv(input logic [3:0] b);
        cen_n = 0; adv_ld = 1; rw_n = 1'($urandom); ce1_n = 1'($urandom); ce2 = 1'($urandom);
        ce3_n = 1'($urandom); addr = AW'($urandom); bw_n = b;
    endtask

    task automatic rd_single(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
        set_load(a, 1'b1, 4'hF); tick();
        set_nop(); tick(); tick();
        chk(dq_oe && dq_out == exp, tag, dq_out, exp);
    endtask

    // burst of four writes from a loaded base; data phases two edges after each command
    task automatic wr_burst(input logic [AW-1:0] a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                            input logic [W-1:0] d2, input logic [W-1:0] d3);
        logic [W-1:0] dv [4];
        dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
        for (int i = 0; i < 6; i++) begin
            if (i == 0) set_load(a, 1'b0, 4'h0);
            else if (i < 4) set_adv(4'h0);
            else set_nop();
            dq_in = (i >= 2) ? dv[i-2] : rnd_word();
            tick();
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d1, d2, dd [4], ee [4];
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < DEPTH; i++) begin
            shadow[i] = '0; sh_ok[i] = 4'h0;
        end
        // R12: reset with a selected read pending on the inputs
        @(negedge clk);
        set_load(10'd3, 1'b1, 4'hF);
        rst_n = 0;
        cur_tag = "R12";
        for (int i = 0; i < 3; i++) tick();
        chk(dq_oe == 1'b0, "R12 dq_oe in reset", W'(dq_oe), '0);
        rst_n = 1;
        set_adv(4'h0);
        tick(); tick(); tick();
        chk(dq_oe == 1'b0, "R12/R8 advance after reset idle", W'(dq_oe), '0);

        // R2, R10, R1: write, read-after-write, partial write
        cur_tag = "R2";
        d1 = rnd_word(); d2 = rnd_word();
        set_load(10'd5, 1'b0, 4'h0); dq_in = rnd_word(); tick();
        set_load(10'd5, 1'b1, 4'hF); dq_in = rnd_word(); tick();
        set_load(10'd5, 1'b0, 4'b1010); dq_in = d1; tick();
        set_nop(); dq_in = rnd_word(); tick();
        chk(dq_oe && dq_out == d1, "R2 read-after-write", dq_out, d1);
        set_nop(); dq_in = d2; tick();
        set_nop(); tick();
        cur_tag = "R10";
        rd_single(10'd5, merge_word(d1, d2, 4'b1010), "R10 byte lanes 0 and 2");
        cur_tag = "R1";
        rd_single(10'd5, merge_word(d1, d2, 4'b1010), "R1 two-edge read");

        // R6: linear burst from low bits 2
        cur_tag = "R6";
        burst_linear = 1;
        for (int i = 0; i < 4; i++) dd[i] = rnd_word();
        wr_burst(10'd6, dd[0], dd[1], dd[2], dd[3]);
        rd_single(10'd6, dd[0], "R6 linear word0");
        rd_single(10'd7, dd[1], "R6 linear word1");
        rd_single(10'd4, dd[2], "R6 linear wrap word2");
        rd_single(10'd5, dd[3], "R6 linear wrap word3");

        // R7: interleaved burst from low bits 1
        cur_tag = "R7";
        burst_linear = 0;
        for (int i = 0; i < 4; i++) ee[i] = rnd_word();
        wr_burst(10'd9, ee[0], ee[1], ee[2], ee[3]);

        // R8: advances after a deselect must not write
        cur_tag = "R8";
        set_nop(); tick();
        for (int i = 0; i < 4; i++) begin
            set_adv(4'h0); rw_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; dq_in = rnd_word(); tick();
        end
        set_nop(); tick(); tick();
        cur_tag = "R7";
        rd_single(10'd9,  ee[0], "R7 interleaved word0 / R8");
        rd_single(10'd8,  ee[1], "R7 interleaved word1 / R8");
        rd_single(10'd11, ee[2], "R7 interleaved word2 / R8");
        rd_single(10'd10, ee[3], "R7 interleaved word3 / R8");

        // R9: read burst with rw_n toggling on advances keeps reading
        cur_tag = "R9";
        burst_linear = 1;
        set_load(10'd4, 1'b1, 4'hF); dq_in = rnd_word(); tick();
        set_adv(4'h0); dq_in = rnd_word(); tick();
        set_adv(4'h0); rw_n = 0; dq_in = rnd_word(); tick();
        chk(dq_oe && dq_out == dd[2], "R9 burst read word0", dq_out, dd[2]);
        set_nop(); dq_in = rnd_word(); tick();
        chk(dq_oe && dq_out == dd[3], "R9 advance kept read type", dq_out, dd[3]);
        set_nop(); tick();
        chk(dq_oe && dq_out == dd[0], "R9 advance with rw_n low still reads", dq_out, dd[0]);

        // R5: deselect right after a read; read completes, bus released afterwards
        cur_tag = "R5";
        set_load(10'd6, 1'b1, 4'hF); tick();
        set_nop(); ce2 = 0; ce1_n = 0; tick();
        set_nop(); tick();
        chk(dq_oe && dq_out == dd[0], "R5 in-flight read completes", dq_out, dd[0]);
        tick();
        chk(dq_oe == 1'b0, "R5 released after deselect", W'(dq_oe), '0);

        // R4: stall while driving
        cur_tag = "R4";
        set_load(10'd7, 1'b1, 4'hF); tick();
        set_nop(); tick(); tick();
        cen_n = 1; set_load(10'd4, 1'b0, 4'h0); cen_n = 1; dq_in = rnd_word();
        tick(); tick(); tick();
        chk(dq_oe && dq_out == dd[1], "R4 output held during stall", dq_out, dd[1]);

        // R11: output enable acts between edges
        #3 oe_n = 1;
        #2 chk(dq_oe == 1'b0 && dq_out == '0, "R11 oe_n high releases", dq_out, '0);
        oe_n = 0;
        #2 chk(dq_oe == 1'b1 && dq_out == dd[1], "R11 oe_n low restores", dq_out, dd[1]);
        set_nop(); tick(); tick();
        rd_single(10'd4, dd[2], "R4 stalled write had no effect");

        // R3: random back-to-back traffic against the reference model
        cur_tag = "R3";
        for (int c = 0; c < 4000; c++) begin
            int d;
            if (c % 256 == 0) burst_linear = 1'($urandom);
            cen_n  = (($urandom % 100) < 8);
            adv_ld = (($urandom % 100) < 35);
            d = $urandom % 12;
            ce1_n = (d == 0); ce2 = (d != 1); ce3_n = (d == 2);
            rw_n  = 1'($urandom);
            bw_n  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            addr  = AW'($urandom % 16);
            dq_in = rnd_word();
            oe_n  = (($urandom % 100) < 10);
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule